// File: doc/BRIEF.md
# GPIO Port Register Block

This block holds the software-visible state for a bank of general-purpose I/O ports of eight pins each. A small register bus carries byte and halfword accesses. Through it software gives every pin a two-bit direction code, writes the levels that output pins drive, and reads back the synchronized pad levels. A per-pin mode bit hands a pin to its peripheral function instead of GPIO use.

Toward the pads the block produces an output enable, an output level and a peripheral-select flag for every pin. It takes in the raw pad input levels. After reset every pin sits in a protected high-impedance state that is neither input nor output, so no pad is driven until software selects an output.

Registers are placed per port `n` at these byte offsets:

| Register | Offset | Access size |
|---|---|---|
| direction | `0x000 + 2n` | halfword |
| output data | `0x040 + n` | byte |
| input data | `0x060 + n` | byte |
| mode | `0x080 + n` | byte |

A flat pin index `i` maps to port `i/8`, bit `i%8`.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset all direction fields are 2'b00, all mode bits are 0 and all output data bits are 0, so pad_oe, pad_out and pad_periph are all zero.
- R2: A halfword write to offset 0x000+2n stores the direction of port n, two bits per pin with pin k at bits [2k+1:2k]. A halfword read returns the stored value unchanged, including 2'b00 and 2'b01.
- R3: pad_oe of pin i is 1 only when its mode bit is 0 and its direction field is 2'b11. The codes 2'b00 (unused, high-impedance), 2'b01 and 2'b10 (input) leave it 0.
- R4: A byte write to offset 0x040+n stores the output data of port n from wdata[7:0]. pad_out[8n+k] follows bit k, and a byte read returns the value in rdata[7:0] with the upper byte zero.
- R5: A byte read of offset 0x060+n returns the pad_in levels of port n through a two-flop synchronizer. A read captured on the first or second rising edge after a pad change returns the old level. A read captured on the third edge returns the new level.
- R6: Writes to the input data offsets change no register and no pad output.
- R7: A byte write to offset 0x080+n stores the mode bits of port n. pad_periph[8n+k] follows bit k, and a pin with its mode bit at 1 has pad_oe at 0 whatever its direction.
- R8: An access of the wrong size is ignored. This covers a byte access to a direction offset, a halfword access to an output data, input data or mode offset, and a halfword access at an odd address. Such a write changes nothing, and such a read returns 0.
- R9: Every read request is answered by bus_rvalid one cycle later. Offsets that do not belong to an existing port, or to any register, read as 0 and ignore writes. bus_rvalid and bus_rdata are 0 in cycles with no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_valid | input | 1 | access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | ADDR_W | byte offset |
| bus_wdata | input | 16 | write data (byte writes use bits 7:0) |
| bus_rvalid | output | 1 | read response valid |
| bus_rdata | output | 16 | read response data |
| pad_in | input | NUM_PORTS*8 | pad input levels |
| pad_oe | output | NUM_PORTS*8 | per-pin output enable |
| pad_out | output | NUM_PORTS*8 | per-pin output level |
| pad_periph | output | NUM_PORTS*8 | per-pin peripheral-select flag |

## Verification
All register state maps onto the pad outputs within one cycle of the write that changes it. A direction, mode or output data bit stored in the wrong place therefore shows up on pad_oe, pad_out or pad_periph at the next sampling point. The same fault also appears in the readback one cycle after the read request. A decode fault shows up in the same way: an access of the wrong size, an access to an unmapped port, or a write to input data that lands in some register. The pads move where they should stay put, and the readback differs from the value kept earlier. Synchronizer depth errors show up as an input read that returns the new level one edge early or late around a pad change.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic                   bus_half,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [15:0]            bus_wdata,
  output logic                   bus_rvalid,
  output logic [15:0]            bus_rdata,
  input  logic [NUM_PORTS*8-1:0] pad_in,
  output logic [NUM_PORTS*8-1:0] pad_oe,
  output logic [NUM_PORTS*8-1:0] pad_out,
  output logic [NUM_PORTS*8-1:0] pad_periph
);
  localparam int NPINS    = NUM_PORTS * 8;
  localparam int DIR_BASE = 'h000;
  localparam int ODR_BASE = 'h040;
  localparam int IDR_BASE = 'h060;
  localparam int MOD_BASE = 'h080;

  logic [2*NPINS-1:0]   dir_q;
  logic [NPINS-1:0]     odr_q, mode_q, sync1_q, sync2_q;
  logic [NUM_PORTS-1:0] dir_sel, odr_sel, idr_sel, mod_sel;
  logic [15:0]          rd_mux;

  wire do_wr = bus_valid & bus_write;
  wire do_rd = bus_valid & ~bus_write;

  always_comb begin
    for (int n = 0; n < NUM_PORTS; n++) begin
      dir_sel[n] = bus_half  & (bus_addr == ADDR_W'(DIR_BASE + 2*n));
      odr_sel[n] = ~bus_half & (bus_addr == ADDR_W'(ODR_BASE + n));
      idr_sel[n] = ~bus_half & (bus_addr == ADDR_W'(IDR_BASE + n));
      mod_sel[n] = ~bus_half & (bus_addr == ADDR_W'(MOD_BASE + n));
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NUM_PORTS; n++) begin
      if (dir_sel[n]) rd_mux = dir_q[16*n +: 16];
      if (odr_sel[n]) rd_mux = {8'h00, odr_q[8*n +: 8]};
      if (idr_sel[n]) rd_mux = {8'h00, sync2_q[8*n +: 8]};
      if (mod_sel[n]) rd_mux = {8'h00, mode_q[8*n +: 8]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      odr_q  <= '0;
      mode_q <= '0;
    end else if (do_wr) begin
      for (int n = 0; n < NUM_PORTS; n++) begin
        if (dir_sel[n]) dir_q[16*n +: 16] <= bus_wdata;
        if (odr_sel[n]) odr_q[8*n +: 8]   <= bus_wdata[7:0];
        if (mod_sel[n]) mode_q[8*n +: 8]  <= bus_wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= do_rd;
      bus_rdata  <= do_rd ? rd_mux : 16'h0000;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pad_oe[i] = ~mode_q[i] & dir_q[2*i+1] & dir_q[2*i];
  end

  assign pad_out    = odr_q;
  assign pad_periph = mode_q;

endmodule

module gpio_port_regs_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             bus_rvalid,
  input logic [15:0]      bus_rdata,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_periph
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_periph == '0));

  p_periph_blocks_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_periph) == '0);

  p_read_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  p_idle_response_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> (!bus_rvalid && bus_rdata == 16'h0000));

  p_pads_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_periph)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_periph(pad_periph)
);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
  localparam int NP    = 4;
  localparam int NPINS = NP * 8;
  localparam int AW    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             bus_valid = 1'b0, bus_write = 1'b0, bus_half = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [15:0]      bus_wdata = '0;
  logic             bus_rvalid;
  logic [15:0]      bus_rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_oe, pad_out, pad_periph;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  gpio_port_regs #(.NUM_PORTS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_periph(pad_periph)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic h, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_half = h; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic h, input logic [15:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_half = h; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected response actual=%h expected=none", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 out", pad_out, 32'h0);
    chk("R1 periph", pad_periph, 32'h0);
    rd(12'h002, 1'b1, 16'h0000, "R1 dir reset");

    wr(12'h002, 1'b1, 16'hC3E4);
    rd(12'h002, 1'b1, 16'hC3E4, "R2 dir readback");
    chk("R3 oe codes", pad_oe, 32'h0000_9800);

    wr(12'h041, 1'b0, 16'h005A);
    chk("R4 pad_out", pad_out, 32'h0000_5A00);
    rd(12'h041, 1'b0, 16'h005A, "R4 odr readback");

    wr(12'h081, 1'b0, 16'h0008);
    chk("R7 periph", pad_periph, 32'h0000_0800);
    chk("R7 oe masked", pad_oe, 32'h0000_9000);
    rd(12'h081, 1'b0, 16'h0008, "R7 mode readback");

    wr(12'h002, 1'b0, 16'hFFFF);
    rd(12'h002, 1'b1, 16'hC3E4, "R8 byte to dir");
    wr(12'h003, 1'b1, 16'hFFFF);
    rd(12'h002, 1'b1, 16'hC3E4, "R8 odd halfword");
    wr(12'h041, 1'b1, 16'hFFFF);
    chk("R8 half to odr", pad_out, 32'h0000_5A00);
    rd(12'h041, 1'b1, 16'h0000, "R8 half read odr");
    wr(12'h081, 1'b1, 16'hFFFF);
    chk("R8 half to mode", pad_periph, 32'h0000_0800);

    wr(12'h061, 1'b0, 16'h00FF);
    chk("R6 out after idr write", pad_out, 32'h0000_5A00);
    chk("R6 oe after idr write", pad_oe, 32'h0000_9000);
    rd(12'h061, 1'b0, 16'h0000, "R6 idr unchanged");

    @(negedge clk);
    pad_in = 32'h00A5_0000;
    bus_valid = 1'b1; bus_write = 1'b0; bus_half = 1'b0; bus_addr = 12'h062;
    exp_q.push_back(16'h0000); tag_q.push_back("R5 edge1 old");
    @(negedge clk);
    exp_q.push_back(16'h0000); tag_q.push_back("R5 edge2 old");
    @(negedge clk);
    exp_q.push_back(16'h00A5); tag_q.push_back("R5 edge3 new");
    @(negedge clk);
    bus_valid = 1'b0;
    rd(12'h062, 1'b1, 16'h0000, "R8 half read idr");

    wr(12'h044, 1'b0, 16'h00FF);
    chk("R9 unmapped write", pad_out, 32'h0000_5A00);
    rd(12'h044, 1'b0, 16'h0000, "R9 unmapped odr");
    rd(12'h008, 1'b1, 16'h0000, "R9 unmapped dir");
    rd(12'h0C0, 1'b0, 16'h0000, "R9 hole");

    wr(12'h006, 1'b1, 16'hFFFF);
    wr(12'h043, 1'b0, 16'h0081);
    chk("R3 last port oe", pad_oe, 32'hFF00_9000);
    chk("R4 last port out", pad_out, 32'h8100_5A00);

    wr(12'h000, 1'b1, 16'h5555);
    chk("R3 code 01 no oe", pad_oe, 32'hFF00_9000);
    rd(12'h000, 1'b1, 16'h5555, "R2 code 01 readback");
    wr(12'h000, 1'b1, 16'hAAAA);
    chk("R3 input no oe", pad_oe, 32'hFF00_9000);
    wr(12'h083, 1'b0, 16'h00F0);
    chk("R7 last port oe", pad_oe, 32'h0F00_9000);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule